// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block turns a two-channel serial audio stream into parallel samples. The stream arrives on three lines: a bit clock, a frame clock that tells left from right, and a data line. The receiver puts out one left and one right sample per frame, together with a one-cycle valid strobe. A 3-bit format code sets four things: the number of bit clocks in each channel half (24 or 32), the word length (16 or 24), whether the word sits at the start or the end of the half, and whether the word starts one bit clock after the frame-clock edge.

In slave mode the block follows a bit clock and a frame clock driven from outside. These must already be synchronised to the system clock. In master mode the block makes both clocks itself, stepping them on a system-clock enable, and the frame rate is the bit rate divided by 64. Two polarity inputs choose the sampling edge of the bit clock and which frame-clock level marks the left channel. A format code that is reserved, or that is not allowed in the current role, raises an error output and stops all samples.

Top module: `aud_ser_rx`

## Requirements
- R1: The format code `cfg_mode` selects the format below. The columns are bit clocks per half, word length, word position and one-bit delay. 0 = 32/24/start/no, 1 = 32/24/start/yes, 2 = 32/16/end/no, 3 = 32/24/end/no, 4 = 24/24/start/no, 6 = 24/16/end/no, 7 = 24/24/end/no. With the delay, the first word bit is at bit index 1 of the half. Without it, the first word bit is at index 0 for start-placed words and at index (half length − word length) for end-placed words. Index 0 is the first active bit-clock edge on which the new frame-clock level is seen.
- R2: Words are received MSB first. A 16-bit word appears in bits [23:8] of the 24-bit sample, and bits [7:0] are zero.
- R3: In end-placed formats the bits of a half that come before the word are discarded, whatever their value.
- R4: Code 5 is reserved. While it is selected, `mode_err` is 1 and `smp_valid` never rises.
- R5: In master mode, codes 4, 6 and 7 set `mode_err` to 1 and produce no samples. In slave mode these codes are accepted.
- R6: With `cfg_sclk_pol` = 1, data is sampled on rising bit-clock edges. With 0, it is sampled on falling edges.
- R7: With `cfg_fs_pol` = 0, a low frame clock marks the left channel. With 1, a high frame clock marks the left channel.
- R8: `smp_valid` is high for exactly one system clock. It rises one cycle after the system clock that sees the active bit-clock edge carrying the last bit of a right word. `smp_left` and `smp_right` change only together with it and hold their values in between.
- R9: In master mode, `sclk_out` toggles once per `tick`. Each frame-clock half spans 32 active bit-clock edges. `fs_out` changes only together with the non-sampling edge of `sclk_out`.
- R10: In slave mode, once the block is locked to the frame clock, a frame-clock change that arrives when the bit count is anything other than the last position of the half sets `frame_err`. The flag stays set until reset. The count restarts from that edge, so the next whole frame is received correctly.
- R11: After reset, all outputs are zero. No sample is issued until the frame clock has changed once and a complete left word and then a complete right word have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Format code (R1) |
| cfg_master | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfg_sclk_pol | input | 1 | Sampling-edge select of the bit clock |
| cfg_fs_pol | input | 1 | Frame-clock level that marks left |
| tick | input | 1 | Bit-clock step enable in master mode |
| sclk_in | input | 1 | External bit clock, already synchronised |
| fs_in | input | 1 | External frame clock, already synchronised |
| sd_in | input | 1 | Serial data |
| sclk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame clock |
| smp_left | output | 24 | Left sample |
| smp_right | output | 24 | Right sample |
| smp_valid | output | 1 | One-cycle sample strobe |
| mode_err | output | 1 | Format code not usable in the current role |
| frame_err | output | 1 | Sticky framing error |

## Verification
A bit counter that has drifted shows up at the ports within one channel half. Either the strobe moves away from the cycle just after the last bit of the right word, or the sample comes out with its bits shifted by one. A wrong left/right decision or a lost lock flag appears in the same way: the strobe is missing, or it carries the wrong word in the first frame after the fault. A framing error that was missed, or raised without cause, is visible on `frame_err` at the frame-clock edge that triggered it.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 6;

  typedef struct packed {
    logic [CNT_W-1:0] slot;
    logic [4:0]       wlen;
    logic             rjust;
    logic             dly;
    logic             slave_only;
    logic             reserved;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f = '{slot: 6'd32, wlen: 5'd24, rjust: 1'b0, dly: 1'b0,
          slave_only: 1'b0, reserved: 1'b0};
    case (code)
      3'd1: f.dly = 1'b1;
      3'd2: begin f.wlen = 5'd16; f.rjust = 1'b1; end
      3'd3: f.rjust = 1'b1;
      3'd4: begin f.slot = 6'd24; f.slave_only = 1'b1; end
      3'd5: f.reserved = 1'b1;
      3'd6: begin f.slot = 6'd24; f.wlen = 5'd16; f.rjust = 1'b1; f.slave_only = 1'b1; end
      3'd7: begin f.slot = 6'd24; f.rjust = 1'b1; f.slave_only = 1'b1; end
      default: ;
    endcase
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] word_first(input fmt_t f);
    if (f.rjust) return f.slot - {1'b0, f.wlen};
    return {{(CNT_W-1){1'b0}}, f.dly};
  endfunction

  function automatic logic [CNT_W-1:0] word_last(input fmt_t f);
    return word_first(f) + {1'b0, f.wlen} - 6'd1;
  endfunction

  function automatic logic [SAMPLE_W-1:0] align_word(input fmt_t f,
                                                     input logic [SAMPLE_W-1:0] sh);
    if (f.wlen == 5'd16) return {sh[15:0], 8'h00};
    return sh;
  endfunction

endpackage

// File: rtl/aud_rx_clkgen.sv
module aud_rx_clkgen #(
  parameter int HALF_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic sclk_pol,
  input  logic fs_pol,
  output logic sclk_gen,
  output logic fs_gen
);
  localparam int PW = HALF_LOG2 + 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (!run)   phase <= '0;
    else if (tick)   phase <= phase + 1'b1;
  end

  // odd phase = sampling level, so the frame bit flips on the other edge
  assign sclk_gen = phase[0] ^ ~sclk_pol;
  assign fs_gen   = phase[PW-1] ^ fs_pol;
endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sclk_pol,
  output logic bit_ev
);
  logic sclk_q;
  logic primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      primed <= 1'b0;
    end else begin
      sclk_q <= sclk;
      primed <= 1'b1;
    end
  end

  assign bit_ev = primed && (sclk != sclk_q) && (sclk == sclk_pol);
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                slave,
  input  logic                fs_pol,
  input  fmt_t                fmt,
  input  logic                bit_ev,
  input  logic                fs_lvl,
  input  logic                sd,
  output logic                word_done,
  output logic                word_right,
  output logic [SAMPLE_W-1:0] word_val,
  output logic                frame_err
);
  logic             fs_prev, fs_vld, synced;
  logic [CNT_W-1:0] cnt, cnt_now, first, last;
  logic [SAMPLE_W-1:0] sh, sh_next;
  logic             fs_chg, in_word, sync_now, early_edge;

  assign first    = word_first(fmt);
  assign last     = word_last(fmt);
  assign fs_chg   = fs_vld && (fs_lvl != fs_prev);
  assign cnt_now  = fs_chg ? '0 : ((cnt == '1) ? cnt : cnt + 1'b1);
  assign in_word  = (cnt_now >= first) && (cnt_now <= last);
  assign sync_now = synced || fs_chg;
  assign sh_next  = {sh[SAMPLE_W-2:0], sd};
  assign early_edge = slave && synced && fs_chg && (cnt != fmt.slot - 6'd1);

  assign word_done  = bit_ev && en && sync_now && (cnt_now == last);
  assign word_right = fs_lvl ^ fs_pol;
  assign word_val   = align_word(fmt, sh_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_prev   <= 1'b0;
      fs_vld    <= 1'b0;
      synced    <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      frame_err <= 1'b0;
    end else if (!en) begin
      fs_vld <= 1'b0;
      synced <= 1'b0;
    end else if (bit_ev) begin
      fs_prev <= fs_lvl;
      fs_vld  <= 1'b1;
      cnt     <= cnt_now;
      if (fs_chg)     synced    <= 1'b1;
      if (in_word)    sh        <= sh_next;
      if (early_edge) frame_err <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_rx_out.sv
module aud_rx_out #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         word_done,
  input  logic         word_right,
  input  logic [W-1:0] word_val,
  output logic [W-1:0] smp_left,
  output logic [W-1:0] smp_right,
  output logic         smp_valid
);
  logic [W-1:0] left_hold;
  logic         left_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (!en) begin
        left_ok <= 1'b0;
      end else if (word_done && !word_right) begin
        left_hold <= word_val;
        left_ok   <= 1'b1;
      end else if (word_done && word_right && left_ok) begin
        smp_left  <= left_hold;
        smp_right <= word_val;
        smp_valid <= 1'b1;
        left_ok   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_master,
  input  logic                cfg_sclk_pol,
  input  logic                cfg_fs_pol,
  input  logic                tick,
  input  logic                sclk_in,
  input  logic                fs_in,
  input  logic                sd_in,
  output logic                sclk_out,
  output logic                fs_out,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right,
  output logic                smp_valid,
  output logic                mode_err,
  output logic                frame_err
);
  fmt_t fmt;
  logic en, sclk_sel, fs_sel, bit_ev, word_done, word_right;
  logic [SAMPLE_W-1:0] word_val;

  assign fmt      = decode_fmt(cfg_mode);
  assign mode_err = fmt.reserved || (cfg_master && fmt.slave_only);
  assign en       = !mode_err;

  aud_rx_clkgen #(.HALF_LOG2(5)) i_clkgen (
    .clk(clk), .rst_n(rst_n), .run(cfg_master), .tick(tick),
    .sclk_pol(cfg_sclk_pol), .fs_pol(cfg_fs_pol),
    .sclk_gen(sclk_out), .fs_gen(fs_out));

  assign sclk_sel = cfg_master ? sclk_out : sclk_in;
  assign fs_sel   = cfg_master ? fs_out   : fs_in;

  aud_rx_edge i_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_sel), .sclk_pol(cfg_sclk_pol),
    .bit_ev(bit_ev));

  aud_rx_frame i_frame (
    .clk(clk), .rst_n(rst_n), .en(en), .slave(!cfg_master),
    .fs_pol(cfg_fs_pol), .fmt(fmt), .bit_ev(bit_ev), .fs_lvl(fs_sel),
    .sd(sd_in), .word_done(word_done), .word_right(word_right),
    .word_val(word_val), .frame_err(frame_err));

  aud_rx_out #(.W(SAMPLE_W)) i_out (
    .clk(clk), .rst_n(rst_n), .en(en), .word_done(word_done),
    .word_right(word_right), .word_val(word_val),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid));
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cfg_mode,
  input logic        cfg_master,
  input logic        cfg_sclk_pol,
  input logic        sclk_out,
  input logic        fs_out,
  input logic [23:0] smp_left,
  input logic [23:0] smp_right,
  input logic        smp_valid,
  input logic        mode_err,
  input logic        frame_err,
  input logic        word_done
);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  assert_valid_from_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(word_done));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(smp_left) && $stable(smp_right)));

  // covers R4 and R5
  assert_no_out_bad_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && $past(mode_err)) |-> !smp_valid);

  assert_ferr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  assert_ferr_slave_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !$past(cfg_master));

  assert_fs_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !$stable(fs_out)) |-> (sclk_out != cfg_sclk_pol));

  assert_lowbits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (cfg_mode == 3'd2 || cfg_mode == 3'd6)) |->
      (smp_left[7:0] == 8'h00 && smp_right[7:0] == 8'h00));
endmodule

bind aud_ser_rx aud_ser_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_master(cfg_master),
  .cfg_sclk_pol(cfg_sclk_pol), .sclk_out(sclk_out), .fs_out(fs_out),
  .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
  .mode_err(mode_err), .frame_err(frame_err), .word_done(word_done));

// File: tb/test_aud_ser_rx.sv
module test_aud_ser_rx;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_mode = 3'd1;
  logic        cfg_master = 1'b0, cfg_sclk_pol = 1'b1, cfg_fs_pol = 1'b0;
  logic        tick = 1'b0, sclk_in = 1'b0, fs_in = 1'b1, sd_in = 1'b0;
  logic        sclk_out, fs_out, smp_valid, mode_err, frame_err;
  logic [23:0] smp_left, smp_right;

  int total = 0, bad = 0;
  logic [23:0] hold_l = '0, hold_r = '0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  aud_ser_rx i_aud_ser_rx (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_master(cfg_master),
    .cfg_sclk_pol(cfg_sclk_pol), .cfg_fs_pol(cfg_fs_pol), .tick(tick),
    .sclk_in(sclk_in), .fs_in(fs_in), .sd_in(sd_in), .sclk_out(sclk_out),
    .fs_out(fs_out), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid), .mode_err(mode_err), .frame_err(frame_err));

  // format model, written from the requirement table
  function automatic int slot_of(input int c);
    return (c == 4 || c == 6 || c == 7) ? 24 : 32;
  endfunction
  function automatic int wl_of(input int c);
    return (c == 2 || c == 6) ? 16 : 24;
  endfunction
  function automatic int first_of(input int c);
    if (c == 1) return 1;
    if (c == 2 || c == 3 || c == 6 || c == 7) return slot_of(c) - wl_of(c);
    return 0;
  endfunction
  function automatic logic tx_bit(input int c, input int i, input logic [23:0] w);
    int k;
    k = i - first_of(c);
    if (k >= 0 && k < wl_of(c)) return w[23-k];
    return 1'b1;  // padding, must be dropped
  endfunction
  function automatic logic [23:0] expect_word(input int c, input logic [23:0] w);
    if (wl_of(c) == 16) return {w[23:8], 8'h00};
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one system clock, compared against the expected strobe
  task automatic cyc(input bit expv, input logic [23:0] el, input logic [23:0] er,
                     input string tag);
    @(negedge clk);
    check(smp_valid === expv, tag, "valid", int'(smp_valid), int'(expv));
    if (expv) begin
      check(smp_left === el, tag, "left", int'(smp_left), int'(el));
      check(smp_right === er, tag, "right", int'(smp_right), int'(er));
      hold_l = el;
      hold_r = er;
    end else begin
      check(smp_left === hold_l && smp_right === hold_r, "R8", "hold",
            int'(smp_left), int'(hold_l));
    end
  endtask

  task automatic setup(input int c, input bit m, input bit sp, input bit fp);
    rst_n = 1'b0;
    cfg_mode = 3'(c);
    cfg_master = m;
    cfg_sclk_pol = sp;
    cfg_fs_pol = fp;
    sclk_in = ~sp;
    fs_in = 1'b1 ^ fp;
    sd_in = 1'b0;
    tick = 1'b0;
    hold_l = '0;
    hold_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_half(input int c, input bit right, input logic [23:0] w,
                           input int nbits, input bit expv, input logic [23:0] el,
                           input logic [23:0] er, input string tag);
    for (int i = 0; i < nbits; i++) begin
      bit fire;
      cyc(0, '0, '0, tag);
      sclk_in = ~cfg_sclk_pol;
      fs_in = right ^ cfg_fs_pol;
      sd_in = tx_bit(c, i, w);
      cyc(0, '0, '0, tag);
      cyc(0, '0, '0, tag);
      sclk_in = cfg_sclk_pol;
      fire = expv && right && (i == first_of(c) + wl_of(c) - 1);
      cyc(fire, el, er, tag);
    end
  endtask

  task automatic send_frame(input int c, input string tag);
    logic [23:0] l, r;
    l = 24'($urandom);
    r = 24'($urandom);
    send_half(c, 0, l, slot_of(c), 0, '0, '0, tag);
    send_half(c, 1, r, slot_of(c), 1, expect_word(c, l), expect_word(c, r), tag);
  endtask

  task automatic run_slave(input int c, input bit sp, input bit fp, input int n,
                           input string tag);
    setup(c, 0, sp, fp);
    // a lead-in right half: no sample may come out of it (R11)
    send_half(c, 1, 24'($urandom), slot_of(c), 0, '0, '0, "R11");
    for (int f = 0; f < n; f++) send_frame(c, tag);
    check(mode_err === 1'b0, tag, "mode_err", int'(mode_err), 0);
    check(frame_err === 1'b0, "R10", "no frame error", int'(frame_err), 0);
  endtask

  task automatic run_master(input int c);
    logic sclk_p, fs_p, fs_seen;
    logic [23:0] cur_l, cur_r;
    int idx, act, nvalid;
    bit counted;
    setup(c, 1, 1, 0);
    sclk_p = sclk_out; fs_p = fs_out; fs_seen = fs_out;
    idx = 0; act = 0; nvalid = 0; counted = 0;
    cur_l = 24'($urandom); cur_r = 24'($urandom);
    for (int k = 0; k < 1900; k++) begin
      @(negedge clk);
      if (smp_valid) begin
        nvalid++;
        check(smp_left === cur_l, "R9", "master left", int'(smp_left), int'(cur_l));
        check(smp_right === cur_r, "R9", "master right", int'(smp_right), int'(cur_r));
      end
      if (fs_out !== fs_p)
        check(sclk_out === ~cfg_sclk_pol, "R9", "frame edge on idle level",
              int'(sclk_out), int'(~cfg_sclk_pol));
      if (sclk_out !== sclk_p && sclk_out === cfg_sclk_pol) act++;
      if (sclk_out !== sclk_p && sclk_out === ~cfg_sclk_pol) begin
        if (fs_out !== fs_seen) begin
          if (counted) check(act == 32, "R9", "edges per half", act, 32);
          counted = 1;
          act = 0;
          fs_seen = fs_out;
          idx = 0;
          if (fs_out === cfg_fs_pol) begin
            cur_l = 24'($urandom);
            cur_r = 24'($urandom);
          end
        end else begin
          idx++;
        end
        sd_in = tx_bit(c, idx, (fs_out ^ cfg_fs_pol) ? cur_r : cur_l);
      end
      sclk_p = sclk_out;
      fs_p = fs_out;
      tick = ~tick;
    end
    check(nvalid >= 5, "R9", "master sample count", nvalid, 5);
    check(mode_err === 1'b0, "R5", "mode 1 accepted as master", int'(mode_err), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    setup(1, 0, 1, 0);
    check(smp_valid === 1'b0, "R11", "valid after reset", int'(smp_valid), 0);
    check(smp_left === '0 && smp_right === '0, "R11", "samples after reset",
          int'(smp_left), 0);
    check(frame_err === 1'b0, "R11", "frame_err after reset", int'(frame_err), 0);
    check(mode_err === 1'b0, "R11", "mode_err after reset", int'(mode_err), 0);

    run_slave(1, 1, 0, 3, "R1");   // delayed, default polarities
    run_slave(0, 0, 1, 3, "R6");   // falling edge, R7 high-is-left
    run_slave(2, 1, 0, 3, "R2");   // 16-bit end-placed, pad ones (R3)
    run_slave(3, 1, 1, 3, "R3");
    run_slave(4, 1, 0, 3, "R1");
    run_slave(6, 0, 0, 3, "R2");
    run_slave(7, 1, 1, 3, "R7");

    // R4: reserved code
    setup(5, 0, 1, 0);
    check(mode_err === 1'b1, "R4", "reserved flag", int'(mode_err), 1);
    send_half(5, 1, 24'h123456, 32, 0, '0, '0, "R4");
    for (int f = 0; f < 2; f++) begin
      send_half(5, 0, 24'hABCDEF, 32, 0, '0, '0, "R4");
      send_half(5, 1, 24'h654321, 32, 0, '0, '0, "R4");
    end

    // R5: slave-only code while master
    setup(4, 1, 1, 0);
    check(mode_err === 1'b1, "R5", "slave-only flag", int'(mode_err), 1);
    for (int k = 0; k < 800; k++) begin
      cyc(0, '0, '0, "R5");
      sd_in = 1'(k[2]);
      tick = ~tick;
    end

    run_master(1);

    // R10: short half, then recovery
    setup(0, 0, 1, 0);
    send_half(0, 1, 24'h0, 32, 0, '0, '0, "R10");
    send_frame(0, "R10");
    check(frame_err === 1'b0, "R10", "clean stream", int'(frame_err), 0);
    send_half(0, 0, 24'h5A5A5A, 20, 0, '0, '0, "R10");
    send_half(0, 1, 24'hA5A5A5, 32, 0, '0, '0, "R10");
    check(frame_err === 1'b1, "R10", "early edge flagged", int'(frame_err), 1);
    send_frame(0, "R10");
    send_frame(0, "R10");
    check(frame_err === 1'b1, "R10", "flag sticky", int'(frame_err), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule